// File: doc/BRIEF.md
# Memory Adder Accelerator with Path-Isolation Test Modes

This block is a small accelerator that a processor drives through a register bus and that reaches a word-organised main memory through a request/response master port. In its normal job it fetches two consecutive words from the bottom of memory, adds them, and stores the sum in the word that follows. Software picks the operation through a mode register, supplies operands in two argument registers, launches it with a start bit and polls for completion. The result appears in a return register.

Besides the normal job, the mode register selects several test operations that each exercise one path. One does pure register arithmetic and never touches memory, so it proves the register bus alone. Two read a memory word and return it, which proves the read direction of the master port. One writes an operand to memory, which proves the write direction. A read-only identification register always returns a fixed build number, so software can confirm that the expected build is loaded before it trusts any other result.

The memory port issues one request at a time. It holds each request until the memory accepts it, and it waits for the data of a read before it does anything else.

Top module: `memacc_top`

## Requirements
- R1: The identification register at offset 0x18 always reads 42 (decimal), and writes to that offset have no effect.
- R2: Mode 0 reads word 0 and word 1, writes their sum modulo 2^32 to word 2 (byte address 8), and sets the return register (offset 0x10) to 0.
- R3: In mode 0 the memory sees exactly three accesses in this order: a read of byte address 0, a read of byte address 4, then a write to byte address 8.
- R4: Mode 1 sets the return register to arg1 (offset 0x28) plus arg2 (offset 0x30), modulo 2^32, and issues no memory access.
- R5: Mode 2 issues one read of byte address 0 and returns the word read.
- R6: Mode 3 issues one read of byte address arg1 shifted left by 2 and returns the word read.
- R7: Mode 4 issues one write of arg2 to byte address arg1 shifted left by 2 and sets the return register to 1.
- R8: A mode value above 4 sets the return register to 0xFFFF_FFFF, issues no memory access, and shows done within two clock cycles after the start write is sampled.
- R9: The control register at offset 0x00 has bit 0 = start (writing 1 launches an operation when idle; always reads 0), bit 1 = done (set when an operation finishes, held until the next accepted start clears it), and bit 2 = idle (1 when no operation is in progress).
- R10: While an operation is in progress, writes to mode (offset 0x20), arg1 and arg2 are ignored, and a further start is ignored.
- R11: The master port has at most one request outstanding: a request keeps its valid, address, direction and write data steady until ready is seen, and no new request is raised while read data is awaited.
- R12: After reset, control reads 0x4 (idle, not done), and mode, arg1, arg2 and the return register read 0.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| reg_wen | input | 1 | Register write strobe |
| reg_waddr | input | 8 | Register write byte offset |
| reg_wdata | input | 32 | Register write data |
| reg_raddr | input | 8 | Register read byte offset |
| reg_rdata | output | 32 | Register read data (combinational from reg_raddr) |
| mem_req_valid | output | 1 | Memory request valid |
| mem_req_ready | input | 1 | Memory accepts the request this cycle |
| mem_req_write | output | 1 | 1 = write request, 0 = read request |
| mem_req_addr | output | 32 | Byte address of the request |
| mem_req_wdata | output | 32 | Write data |
| mem_rsp_valid | input | 1 | Read data valid |
| mem_rsp_data | input | 32 | Read data |

## Verification
Mode 0 is tried with random word pairs and with a pair whose sum overflows 32 bits. These separate true modulo addition from a carry leak, and the access log separates the right order of accesses from an order that is swapped or has an access missing. The peek and poke modes use random word indices plus indices 0 and 63, which shows whether the arg1 index is shifted into a byte address or used as-is. Memory ready and response latency are randomised, and at one point ready is held low, so that request holding, the done/idle bits and the ignoring of writes during a busy operation are seen in cycles where they matter. Register-only and undefined modes are checked to leave the access log empty.

// File: rtl/memacc_pkg.sv
package memacc_pkg;

    localparam logic [7:0] OFF_CTRL = 8'h00;
    localparam logic [7:0] OFF_RET  = 8'h10;
    localparam logic [7:0] OFF_ID   = 8'h18;
    localparam logic [7:0] OFF_MODE = 8'h20;
    localparam logic [7:0] OFF_ARG1 = 8'h28;
    localparam logic [7:0] OFF_ARG2 = 8'h30;

    localparam int BUILD_ID = 42;

    localparam int MD_ADD     = 0;
    localparam int MD_REGTEST = 1;
    localparam int MD_PEEK0   = 2;
    localparam int MD_PEEK    = 3;
    localparam int MD_POKE    = 4;

    typedef enum logic [1:0] {SQ_IDLE, SQ_CMD, SQ_WAIT, SQ_FIN} seq_state_e;
    typedef enum logic [1:0] {MP_IDLE, MP_REQ, MP_RSP} port_state_e;

endpackage

// File: rtl/memacc_regs.sv
module memacc_regs
    import memacc_pkg::*;
#(
    parameter int DATA_W = 32,
    parameter int RA_W   = 8
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              wen_i,
    input  logic [RA_W-1:0]   waddr_i,
    input  logic [DATA_W-1:0] wdata_i,
    input  logic [RA_W-1:0]   raddr_i,
    output logic [DATA_W-1:0] rdata_o,
    input  logic              busy_i,
    input  logic              fin_i,
    input  logic [DATA_W-1:0] result_i,
    output logic              start_o,
    output logic              done_o,
    output logic [DATA_W-1:0] mode_o,
    output logic [DATA_W-1:0] arg1_o,
    output logic [DATA_W-1:0] arg2_o
);

    localparam int CTRL_PAD = DATA_W - 3;

    typedef struct packed {
        logic [DATA_W-1:0] mode;
        logic [DATA_W-1:0] arg1;
        logic [DATA_W-1:0] arg2;
        logic [DATA_W-1:0] ret;
        logic              done;
    } regs_t;

    regs_t q, d;
    logic  start;

    always_comb begin
        d     = q;
        start = wen_i && (waddr_i == RA_W'(OFF_CTRL)) && wdata_i[0] && !busy_i;
        if (start) begin
            d.done = 1'b0;
        end
        if (wen_i && !busy_i) begin
            if (waddr_i == RA_W'(OFF_MODE)) d.mode = wdata_i;
            if (waddr_i == RA_W'(OFF_ARG1)) d.arg1 = wdata_i;
            if (waddr_i == RA_W'(OFF_ARG2)) d.arg2 = wdata_i;
        end
        if (fin_i) begin
            d.ret  = result_i;
            d.done = 1'b1;
        end
    end

    always_ff @(posedge clk) begin
        if (!rst_n) begin
            q <= '0;
        end else begin
            q <= d;
        end
    end

    always_comb begin
        rdata_o = '0;
        if (raddr_i == RA_W'(OFF_CTRL)) rdata_o = {{CTRL_PAD{1'b0}}, ~busy_i, q.done, 1'b0};
        if (raddr_i == RA_W'(OFF_RET))  rdata_o = q.ret;
        if (raddr_i == RA_W'(OFF_ID))   rdata_o = DATA_W'(BUILD_ID);
        if (raddr_i == RA_W'(OFF_MODE)) rdata_o = q.mode;
        if (raddr_i == RA_W'(OFF_ARG1)) rdata_o = q.arg1;
        if (raddr_i == RA_W'(OFF_ARG2)) rdata_o = q.arg2;
    end

    assign start_o = start;
    assign done_o  = q.done;
    assign mode_o  = q.mode;
    assign arg1_o  = q.arg1;
    assign arg2_o  = q.arg2;

endmodule

// File: rtl/memacc_seq.sv
module memacc_seq
    import memacc_pkg::*;
#(
    parameter int DATA_W = 32,
    parameter int ADDR_W = 32
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              start_i,
    input  logic [DATA_W-1:0] mode_i,
    input  logic [DATA_W-1:0] arg1_i,
    input  logic [DATA_W-1:0] arg2_i,
    output logic              busy_o,
    output logic              fin_o,
    output logic [DATA_W-1:0] result_o,
    output logic              cmd_valid_o,
    output logic              cmd_write_o,
    output logic [ADDR_W-1:0] cmd_addr_o,
    output logic [DATA_W-1:0] cmd_wdata_o,
    input  logic              cmd_done_i,
    input  logic [DATA_W-1:0] cmd_rdata_i
);

    localparam int BYTES = DATA_W / 8;
    localparam int SHIFT = $clog2(BYTES);

    typedef struct packed {
        seq_state_e        state;
        logic [1:0]        step;
        logic [DATA_W-1:0] acc;
        logic [DATA_W-1:0] result;
    } seq_t;

    seq_t q, d;

    logic m_add, m_reg, m_peek0, m_peek, m_poke;
    assign m_add   = (mode_i == DATA_W'(MD_ADD));
    assign m_reg   = (mode_i == DATA_W'(MD_REGTEST));
    assign m_peek0 = (mode_i == DATA_W'(MD_PEEK0));
    assign m_peek  = (mode_i == DATA_W'(MD_PEEK));
    assign m_poke  = (mode_i == DATA_W'(MD_POKE));

    logic [ADDR_W-1:0] arg_addr;
    assign arg_addr = ADDR_W'(arg1_i) << SHIFT;

    // command fields for the access selected by mode and step
    always_comb begin
        cmd_write_o = 1'b0;
        cmd_addr_o  = '0;
        cmd_wdata_o = '0;
        if (m_add) begin
            cmd_addr_o  = ADDR_W'(q.step) << SHIFT;
            cmd_write_o = (q.step == 2'd2);
            cmd_wdata_o = q.acc;
        end else if (m_peek) begin
            cmd_addr_o  = arg_addr;
        end else if (m_poke) begin
            cmd_addr_o  = arg_addr;
            cmd_write_o = 1'b1;
            cmd_wdata_o = arg2_i;
        end
    end

    always_comb begin
        d = q;
        case (q.state)
            SQ_IDLE: begin
                if (start_i) begin
                    d.step = 2'd0;
                    if (m_add || m_peek0 || m_peek || m_poke) begin
                        d.state = SQ_CMD;
                    end else if (m_reg) begin
                        d.result = arg1_i + arg2_i;
                        d.state  = SQ_FIN;
                    end else begin
                        d.result = '1;
                        d.state  = SQ_FIN;
                    end
                end
            end
            SQ_CMD: begin
                d.state = SQ_WAIT;
            end
            SQ_WAIT: begin
                if (cmd_done_i) begin
                    if (m_add) begin
                        if (q.step == 2'd0) begin
                            d.acc   = cmd_rdata_i;
                            d.step  = 2'd1;
                            d.state = SQ_CMD;
                        end else if (q.step == 2'd1) begin
                            d.acc   = q.acc + cmd_rdata_i;
                            d.step  = 2'd2;
                            d.state = SQ_CMD;
                        end else begin
                            d.result = '0;
                            d.state  = SQ_FIN;
                        end
                    end else if (m_poke) begin
                        d.result = DATA_W'(1);
                        d.state  = SQ_FIN;
                    end else begin
                        d.result = cmd_rdata_i;
                        d.state  = SQ_FIN;
                    end
                end
            end
            default: begin
                d.state = SQ_IDLE;
            end
        endcase
    end

    always_ff @(posedge clk) begin
        if (!rst_n) begin
            q <= '{state: SQ_IDLE, step: 2'd0, acc: '0, result: '0};
        end else begin
            q <= d;
        end
    end

    assign busy_o      = (q.state != SQ_IDLE);
    assign fin_o       = (q.state == SQ_FIN);
    assign result_o    = q.result;
    assign cmd_valid_o = (q.state == SQ_CMD);

endmodule

// File: rtl/memacc_mport.sv
module memacc_mport
    import memacc_pkg::*;
#(
    parameter int DATA_W = 32,
    parameter int ADDR_W = 32
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              cmd_valid_i,
    input  logic              cmd_write_i,
    input  logic [ADDR_W-1:0] cmd_addr_i,
    input  logic [DATA_W-1:0] cmd_wdata_i,
    output logic              cmd_done_o,
    output logic [DATA_W-1:0] cmd_rdata_o,
    output logic              mem_req_valid,
    input  logic              mem_req_ready,
    output logic              mem_req_write,
    output logic [ADDR_W-1:0] mem_req_addr,
    output logic [DATA_W-1:0] mem_req_wdata,
    input  logic              mem_rsp_valid,
    input  logic [DATA_W-1:0] mem_rsp_data
);

    typedef struct packed {
        port_state_e       state;
        logic              write;
        logic [ADDR_W-1:0] addr;
        logic [DATA_W-1:0] wdata;
    } port_t;

    port_t q, d;

    always_comb begin
        d          = q;
        cmd_done_o = 1'b0;
        case (q.state)
            MP_IDLE: begin
                if (cmd_valid_i) begin
                    d.write = cmd_write_i;
                    d.addr  = cmd_addr_i;
                    d.wdata = cmd_wdata_i;
                    d.state = MP_REQ;
                end
            end
            MP_REQ: begin
                if (mem_req_ready) begin
                    if (q.write) begin
                        cmd_done_o = 1'b1;
                        d.state    = MP_IDLE;
                    end else begin
                        d.state    = MP_RSP;
                    end
                end
            end
            MP_RSP: begin
                if (mem_rsp_valid) begin
                    cmd_done_o = 1'b1;
                    d.state    = MP_IDLE;
                end
            end
            default: begin
                d.state = MP_IDLE;
            end
        endcase
    end

    always_ff @(posedge clk) begin
        if (!rst_n) begin
            q <= '{state: MP_IDLE, write: 1'b0, addr: '0, wdata: '0};
        end else begin
            q <= d;
        end
    end

    assign cmd_rdata_o   = mem_rsp_data;
    assign mem_req_valid = (q.state == MP_REQ);
    assign mem_req_write = q.write;
    assign mem_req_addr  = q.addr;
    assign mem_req_wdata = q.wdata;

endmodule

// File: rtl/memacc_top.sv
module memacc_top #(
    parameter int DATA_W = 32,
    parameter int ADDR_W = 32,
    parameter int RA_W   = 8
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              reg_wen,
    input  logic [RA_W-1:0]   reg_waddr,
    input  logic [DATA_W-1:0] reg_wdata,
    input  logic [RA_W-1:0]   reg_raddr,
    output logic [DATA_W-1:0] reg_rdata,
    output logic              mem_req_valid,
    input  logic              mem_req_ready,
    output logic              mem_req_write,
    output logic [ADDR_W-1:0] mem_req_addr,
    output logic [DATA_W-1:0] mem_req_wdata,
    input  logic              mem_rsp_valid,
    input  logic [DATA_W-1:0] mem_rsp_data
);

    logic              start, done, busy, fin;
    logic [DATA_W-1:0] mode, arg1, arg2, result;
    logic              cmd_valid, cmd_write, cmd_done;
    logic [ADDR_W-1:0] cmd_addr;
    logic [DATA_W-1:0] cmd_wdata, cmd_rdata;

    memacc_regs #(.DATA_W(DATA_W), .RA_W(RA_W)) u_regs (
        .clk      (clk),
        .rst_n    (rst_n),
        .wen_i    (reg_wen),
        .waddr_i  (reg_waddr),
        .wdata_i  (reg_wdata),
        .raddr_i  (reg_raddr),
        .rdata_o  (reg_rdata),
        .busy_i   (busy),
        .fin_i    (fin),
        .result_i (result),
        .start_o  (start),
        .done_o   (done),
        .mode_o   (mode),
        .arg1_o   (arg1),
        .arg2_o   (arg2)
    );

    memacc_seq #(.DATA_W(DATA_W), .ADDR_W(ADDR_W)) u_seq (
        .clk         (clk),
        .rst_n       (rst_n),
        .start_i     (start),
        .mode_i      (mode),
        .arg1_i      (arg1),
        .arg2_i      (arg2),
        .busy_o      (busy),
        .fin_o       (fin),
        .result_o    (result),
        .cmd_valid_o (cmd_valid),
        .cmd_write_o (cmd_write),
        .cmd_addr_o  (cmd_addr),
        .cmd_wdata_o (cmd_wdata),
        .cmd_done_i  (cmd_done),
        .cmd_rdata_i (cmd_rdata)
    );

    memacc_mport #(.DATA_W(DATA_W), .ADDR_W(ADDR_W)) u_port (
        .clk           (clk),
        .rst_n         (rst_n),
        .cmd_valid_i   (cmd_valid),
        .cmd_write_i   (cmd_write),
        .cmd_addr_i    (cmd_addr),
        .cmd_wdata_i   (cmd_wdata),
        .cmd_done_o    (cmd_done),
        .cmd_rdata_o   (cmd_rdata),
        .mem_req_valid (mem_req_valid),
        .mem_req_ready (mem_req_ready),
        .mem_req_write (mem_req_write),
        .mem_req_addr  (mem_req_addr),
        .mem_req_wdata (mem_req_wdata),
        .mem_rsp_valid (mem_rsp_valid),
        .mem_rsp_data  (mem_rsp_data)
    );

endmodule

// File: rtl/memacc_checker.sv
module memacc_checker #(
    parameter int DATA_W = 32,
    parameter int ADDR_W = 32,
    parameter int RA_W   = 8
) (
    input logic              clk,
    input logic              rst_n,
    input logic [RA_W-1:0]   reg_raddr,
    input logic [DATA_W-1:0] reg_rdata,
    input logic              mem_req_valid,
    input logic              mem_req_ready,
    input logic              mem_req_write,
    input logic [ADDR_W-1:0] mem_req_addr,
    input logic [DATA_W-1:0] mem_req_wdata,
    input logic              mem_rsp_valid,
    input logic              busy,
    input logic              start,
    input logic              done,
    input logic [DATA_W-1:0] mode
);

    logic outstanding;

    always_ff @(posedge clk) begin
        if (!rst_n) begin
            outstanding <= 1'b0;
        end else if (mem_req_valid && mem_req_ready && !mem_req_write) begin
            outstanding <= 1'b1;
        end else if (mem_rsp_valid) begin
            outstanding <= 1'b0;
        end
    end

    // R1
    a_r1_id_const: assert property (@(posedge clk) disable iff (!rst_n)
        (reg_raddr == RA_W'(8'h18)) |-> (reg_rdata == DATA_W'(42)));

    // R11
    a_r11_req_held: assert property (@(posedge clk) disable iff (!rst_n)
        (mem_req_valid && !mem_req_ready) |=>
            (mem_req_valid && $stable(mem_req_addr) && $stable(mem_req_write) && $stable(mem_req_wdata)));

    // R11
    a_r11_single_outstanding: assert property (@(posedge clk) disable iff (!rst_n)
        outstanding |-> !mem_req_valid);

    // R9
    a_r9_start_clears_done: assert property (@(posedge clk) disable iff (!rst_n)
        start |=> !done);

    // R10
    a_r10_mode_frozen: assert property (@(posedge clk) disable iff (!rst_n)
        busy |=> $stable(mode));

    // R8
    a_r8_undef_quick: assert property (@(posedge clk) disable iff (!rst_n)
        (start && (mode > DATA_W'(4))) |=> (!mem_req_valid ##1 done));

endmodule

bind memacc_top memacc_checker #(.DATA_W(DATA_W), .ADDR_W(ADDR_W), .RA_W(RA_W)) u_chk (
    .clk           (clk),
    .rst_n         (rst_n),
    .reg_raddr     (reg_raddr),
    .reg_rdata     (reg_rdata),
    .mem_req_valid (mem_req_valid),
    .mem_req_ready (mem_req_ready),
    .mem_req_write (mem_req_write),
    .mem_req_addr  (mem_req_addr),
    .mem_req_wdata (mem_req_wdata),
    .mem_rsp_valid (mem_rsp_valid),
    .busy          (busy),
    .start         (start),
    .done          (done),
    .mode          (mode)
);

// File: tb/sim_memacc_top.sv
module sim_memacc_top;

    logic        clk = 1'b0;
    logic        rst_n = 1'b0;
    logic        reg_wen = 1'b0;
    logic [7:0]  reg_waddr = '0;
    logic [31:0] reg_wdata = '0;
    logic [7:0]  reg_raddr = '0;
    logic [31:0] reg_rdata;
    logic        mem_req_valid, mem_req_write;
    logic        mem_req_ready = 1'b0;
    logic [31:0] mem_req_addr, mem_req_wdata;
    logic        mem_rsp_valid = 1'b0;
    logic [31:0] mem_rsp_data = '0;

    always #4 clk = ~clk;

    memacc_top u0 (
        .clk           (clk),
        .rst_n         (rst_n),
        .reg_wen       (reg_wen),
        .reg_waddr     (reg_waddr),
        .reg_wdata     (reg_wdata),
        .reg_raddr     (reg_raddr),
        .reg_rdata     (reg_rdata),
        .mem_req_valid (mem_req_valid),
        .mem_req_ready (mem_req_ready),
        .mem_req_write (mem_req_write),
        .mem_req_addr  (mem_req_addr),
        .mem_req_wdata (mem_req_wdata),
        .mem_rsp_valid (mem_rsp_valid),
        .mem_rsp_data  (mem_rsp_data)
    );

    int          total = 0;
    int          bad = 0;
    bit          finished = 0;
    logic [31:0] mem [64];
    logic        log_wr [32];
    logic [31:0] log_addr [32];
    int          log_n = 0;
    bit          hold_ready = 0;

    // memory model: decides ready at the falling edge, response after a random delay
    initial begin
        bit          pend;
        int          cnt;
        logic [31:0] raddr;
        pend = 0; cnt = 0; raddr = '0;
        forever begin
            @(negedge clk);
            mem_rsp_valid = 1'b0;
            mem_req_ready = 1'b0;
            if (pend) begin
                if (cnt == 0) begin
                    mem_rsp_valid = 1'b1;
                    mem_rsp_data  = mem[raddr[7:2]];
                    pend = 0;
                end else begin
                    cnt--;
                end
            end else if (rst_n && mem_req_valid && !hold_ready && ($urandom % 3 != 0)) begin
                mem_req_ready = 1'b1;
                if (log_n < 32) begin
                    log_wr[log_n]   = mem_req_write;
                    log_addr[log_n] = mem_req_addr;
                end
                log_n++;
                if (mem_req_write) begin
                    mem[mem_req_addr[7:2]] = mem_req_wdata;
                end else begin
                    raddr = mem_req_addr;
                    pend  = 1;
                    cnt   = $urandom % 3;
                end
            end
        end
    end

    task automatic chk(input string req, input logic [31:0] act, input logic [31:0] exp);
        total++;
        if (act !== exp) begin
            bad++;
            $display("FAIL %s actual=%h expected=%h", req, act, exp);
        end
    endtask

    task automatic wr(input logic [7:0] a, input logic [31:0] v);
        @(negedge clk);
        reg_wen = 1'b1; reg_waddr = a; reg_wdata = v;
        @(negedge clk);
        reg_wen = 1'b0;
    endtask

    task automatic rd(input logic [7:0] a, output logic [31:0] v);
        reg_raddr = a;
        #1;
        v = reg_rdata;
    endtask

    task automatic wait_done(input string req);
        logic [31:0] v;
        for (int i = 0; i < 400; i++) begin
            @(negedge clk);
            rd(8'h00, v);
            if (v[1]) return;
        end
        chk(req, 32'hDEAD, 32'h0);
    endtask

    task automatic run_op(input logic [31:0] md, input logic [31:0] a1, input logic [31:0] a2,
                          output logic [31:0] ret);
        wr(8'h20, md); wr(8'h28, a1); wr(8'h30, a2);
        log_n = 0;
        wr(8'h00, 32'h1);
        wait_done("R9");
        rd(8'h10, ret);
    endtask

    function automatic logic [31:0] exp_sum(input logic [31:0] a, input logic [31:0] b);
        return a + b;
    endfunction

    task automatic do_add(input logic [31:0] w0, input logic [31:0] w1);
        logic [31:0] r;
        mem[0] = w0; mem[1] = w1;
        run_op(32'd0, $urandom, $urandom, r);
        chk("R2 ret", r, 32'h0);
        chk("R2 word2", mem[2], exp_sum(w0, w1));
        chk("R3 count", 32'(log_n), 32'd3);
        chk("R3 first", {31'b0, log_wr[0]} ^ log_addr[0], 32'h0);
        chk("R3 second", {31'b0, log_wr[1]} ^ log_addr[1], 32'h4);
        chk("R3 third", {31'b0, log_wr[2]} ^ log_addr[2], 32'h9);
    endtask

    initial begin
        logic [31:0] v, r, a1, a2, idx;
        void'($urandom(32'd1234));
        for (int i = 0; i < 64; i++) mem[i] = $urandom;
        repeat (3) @(negedge clk);
        rst_n = 1'b1;
        @(negedge clk);

        // R12 reset values
        rd(8'h00, v); chk("R12 ctrl", v, 32'h4);
        rd(8'h10, v); chk("R12 ret", v, 32'h0);
        rd(8'h20, v); chk("R12 mode", v, 32'h0);
        rd(8'h28, v); chk("R12 arg1", v, 32'h0);
        rd(8'h30, v); chk("R12 arg2", v, 32'h0);

        // R1 identification
        rd(8'h18, v); chk("R1 id", v, 32'd42);
        wr(8'h18, 32'h5555_AAAA);
        rd(8'h18, v); chk("R1 id after write", v, 32'd42);

        // R4 register-only arithmetic
        run_op(32'd1, 32'hFFFF_FFFF, 32'd2, r);
        chk("R4 wrap", r, 32'd1);
        chk("R4 no access", 32'(log_n), 32'd0);
        for (int i = 0; i < 6; i++) begin
            a1 = $urandom; a2 = $urandom;
            run_op(32'd1, a1, a2, r);
            chk("R4 sum", r, exp_sum(a1, a2));
            chk("R4 no access", 32'(log_n), 32'd0);
        end

        // R9 start reads 0, done sticky
        rd(8'h00, v); chk("R9 ctrl after op", v, 32'h6);
        repeat (20) @(negedge clk);
        rd(8'h00, v); chk("R9 done held", v, 32'h6);

        // R2 / R3 normal job
        do_add(32'hFFFF_FFFF, 32'h0000_0003);
        do_add(32'h8000_0000, 32'h8000_0000);
        for (int i = 0; i < 6; i++) do_add($urandom, $urandom);

        // R5 peek word 0
        for (int i = 0; i < 3; i++) begin
            mem[0] = $urandom;
            run_op(32'd2, $urandom, $urandom, r);
            chk("R5 value", r, mem[0]);
            chk("R5 addr", log_addr[0], 32'h0);
        end

        // R6 peek indexed, includes corner indices 0 and 63
        for (int i = 0; i < 8; i++) begin
            idx = (i == 0) ? 32'd0 : (i == 1) ? 32'd63 : ($urandom % 64);
            run_op(32'd3, idx, $urandom, r);
            chk("R6 value", r, mem[idx[5:0]]);
            chk("R6 addr", log_addr[0], idx << 2);
            chk("R6 count", 32'(log_n), 32'd1);
        end

        // R7 poke
        for (int i = 0; i < 8; i++) begin
            idx = (i == 0) ? 32'd63 : (i == 1) ? 32'd5 : ($urandom % 64);
            a2 = $urandom;
            run_op(32'd4, idx, a2, r);
            chk("R7 ret", r, 32'd1);
            chk("R7 stored", mem[idx[5:0]], a2);
            chk("R7 access", {31'b0, log_wr[0]} ^ log_addr[0], (idx << 2) | 32'h1);
        end

        // R8 undefined modes
        foreach (a1[k]) begin end
        for (int i = 0; i < 3; i++) begin
            v = (i == 0) ? 32'd5 : (i == 1) ? 32'hFFFF_FFFF : (32'd5 + ($urandom % 1000));
            wr(8'h20, v);
            log_n = 0;
            wr(8'h00, 32'h1);
            @(negedge clk);
            rd(8'h00, r); chk("R8 quick done", r & 32'h2, 32'h2);
            rd(8'h10, r); chk("R8 ret", r, 32'hFFFF_FFFF);
            chk("R8 no access", 32'(log_n), 32'd0);
        end

        // R9 / R10 / R11 while the memory stalls
        mem[0] = 32'h0000_1111; mem[1] = 32'h0000_2222;
        wr(8'h20, 32'd0); wr(8'h28, 32'd9); wr(8'h30, 32'd7);
        hold_ready = 1;
        log_n = 0;
        wr(8'h00, 32'h1);
        repeat (2) @(negedge clk);
        rd(8'h00, v); chk("R9 busy ctrl", v, 32'h0);
        chk("R11 valid raised", {31'b0, mem_req_valid}, 32'h1);
        wr(8'h20, 32'd1); wr(8'h28, 32'd50); wr(8'h30, 32'd60);
        wr(8'h00, 32'h1);
        rd(8'h20, v); chk("R10 mode kept", v, 32'd0);
        rd(8'h28, v); chk("R10 arg1 kept", v, 32'd9);
        rd(8'h30, v); chk("R10 arg2 kept", v, 32'd7);
        chk("R11 valid held", {31'b0, mem_req_valid}, 32'h1);
        chk("R11 addr held", mem_req_addr, 32'h0);
        hold_ready = 0;
        wait_done("R9");
        rd(8'h10, r); chk("R10 ret of first op", r, 32'h0);
        chk("R10 word2", mem[2], 32'h0000_3333);
        repeat (20) @(negedge clk);
        chk("R10 second start ignored", 32'(log_n), 32'd3);
        rd(8'h00, v); chk("R9 idle after", v, 32'h6);

        if (!finished) begin
            finished = 1;
            $display("test done: total=%0d bad=%0d", total, bad);
            $finish;
        end
    end

    initial begin
        repeat (150000) @(posedge clk);
        if (!finished) begin
            finished = 1;
            total++; bad++;
            $display("FAIL watchdog actual=running expected=finished");
            $display("test done: total=%0d bad=%0d", total, bad);
            $finish;
        end
    end

endmodule